// File: doc/BRIEF.md
# Interrupt Line State Tracker

This block keeps the service state of a bank of interrupt lines. Each line is in one of four states: idle, waiting, in service, or in service with a new request waiting. Two state bits per line encode them, `pending` and `active`. A line changes state on its hardware request input, on software strobes that set or clear its waiting flag, and on processor strobes that mark entry into and return from its handler. Each strobe carries a line index.

A configuration bit for each line selects how the line treats its request. A level line follows the request input. It re-samples that input when its handler returns. An edge line latches each rising edge of its request input, including edges that arrive while its handler runs. The block does not choose which line to serve. A separate arbiter reads the `pending` and `active` vectors and drives the entry and return strobes.

All updates are synchronous to `clk`. Each event shows on the outputs one cycle after the clock edge that samples it.

Top module: `irq_state_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every line goes idle: both `pending` and `active` read 0 after that edge. Bit i of every vector belongs to line i.
- R2: A level line (`cfg_pulse[i]`=0) whose request is sampled high while it is not active has `pending` set after that edge.
- R3: An edge line (`cfg_pulse[i]`=1) sets `pending` when its request is sampled high after being sampled low. A high level that lasts one cycle is enough. A request that stays high sets `pending` only once.
- R4: A set strobe sets `pending` on its line whatever the line's mode. If set and clear strobes target the same line in the same cycle, the set wins.
- R5: An entry strobe on a waiting line clears `pending` and sets `active`. An entry strobe on a line that is not waiting has no effect.
- R6: A clear strobe on a level line leaves `pending` set while the request is high. It clears `pending` when the request is low.
- R7: A clear strobe on an edge line clears `pending`. A line that was in service with a request waiting stays active.
- R8: A return strobe on an active level line clears `active`. After that edge, `pending` equals the sampled request.
- R9: A rising edge on an active edge line sets `pending` while `active` stays set. At return such a line becomes waiting. Without a new edge it becomes idle at return.
- R10: A return strobe on a line that is not active has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NLINES | Hardware request per line |
| cfg_pulse | input | NLINES | Per-line mode: 1 edge, 0 level |
| set_stb | input | 1 | Software set-waiting strobe |
| set_idx | input | IW | Line index for `set_stb` |
| clr_stb | input | 1 | Software clear-waiting strobe |
| clr_idx | input | IW | Line index for `clr_stb` |
| enter_stb | input | 1 | Handler entry strobe |
| enter_idx | input | IW | Line index for `enter_stb` |
| exit_stb | input | 1 | Handler return strobe |
| exit_idx | input | IW | Line index for `exit_stb` |
| pending | output | NLINES | Waiting flag per line |
| active | output | NLINES | In-service flag per line |

## Verification
The bench builds the block with `NLINES` = 8. Lines 0 to 3 are level lines and lines 4 to 7 are edge lines. With eight lines, random strobes often hit the same line at once, so entry and return in one cycle, set against clear, and strobes that land on an edge in progress all occur many times in a few hundred cycles. Directed sequences take single lines through every state change in both modes. A behavioural model compares both output vectors on every clock.

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NLINES = 32,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req,
  input  logic [NLINES-1:0] cfg_pulse,
  input  logic              set_stb,
  input  logic [IW-1:0]     set_idx,
  input  logic              clr_stb,
  input  logic [IW-1:0]     clr_idx,
  input  logic              enter_stb,
  input  logic [IW-1:0]     enter_idx,
  input  logic              exit_stb,
  input  logic [IW-1:0]     exit_idx,
  output logic [NLINES-1:0] pending,
  output logic [NLINES-1:0] active
);

  logic [NLINES-1:0] pend_q, act_q, req_d, pend_n, act_n;
  wire  [NLINES-1:0] rise = req & ~req_d;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    wire hit_set   = set_stb   && (set_idx   == IW'(i));
    wire hit_clr   = clr_stb   && (clr_idx   == IW'(i));
    wire hit_enter = enter_stb && (enter_idx == IW'(i)) && pend_q[i];
    wire hit_exit  = exit_stb  && (exit_idx  == IW'(i)) && act_q[i];

    always_comb begin
      logic p, a;
      p = pend_q[i];
      a = act_q[i];
      if (hit_exit) begin
        a = 1'b0;
        if (!cfg_pulse[i]) p = req[i];
      end
      if (hit_enter) begin
        p = 1'b0;
        a = 1'b1;
      end
      if (hit_clr) p = cfg_pulse[i] ? 1'b0 : (p & req[i]);
      if (hit_set) p = 1'b1;
      if (cfg_pulse[i] ? rise[i] : (req[i] & ~a)) p = 1'b1;
      pend_n[i] = p;
      act_n[i]  = a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      req_d  <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
      req_d  <= req;
    end
  end

  assign pending = pend_q;
  assign active  = act_q;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (pending == '0 && active == '0));

  p_enter_sets_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_stb && pending[enter_idx]) |=> active[$past(enter_idx)]);

  p_level_return_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_stb && active[exit_idx] && !cfg_pulse[exit_idx] && !req[exit_idx]
     && !(set_stb && set_idx == exit_idx) && !(enter_stb && enter_idx == exit_idx))
    |=> (!pending[$past(exit_idx)] && !active[$past(exit_idx)]));

  p_pulse_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && cfg_pulse[clr_idx] && !req[clr_idx] && !(set_stb && set_idx == clr_idx))
    |=> !pending[$past(clr_idx)]);

  p_return_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_stb && !active[exit_idx] && !(enter_stb && enter_idx == exit_idx))
    |=> !active[$past(exit_idx)]);

endmodule

// File: tb/irq_state_bank_test.sv
module irq_state_bank_test;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic [N-1:0] cfg_pulse = 8'hF0;
  logic set_stb = 0, clr_stb = 0, enter_stb = 0, exit_stb = 0;
  logic [IW-1:0] set_idx = '0, clr_idx = '0, enter_idx = '0, exit_idx = '0;
  logic [N-1:0] pending, active;

  irq_state_bank #(.NLINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_pulse(cfg_pulse),
    .set_stb(set_stb), .set_idx(set_idx), .clr_stb(clr_stb), .clr_idx(clr_idx),
    .enter_stb(enter_stb), .enter_idx(enter_idx), .exit_stb(exit_stb), .exit_idx(exit_idx),
    .pending(pending), .active(active));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int st[N];
  bit prv[N];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mpend();
    for (int i = 0; i < N; i++) mpend[i] = (st[i] == 1 || st[i] == 3);
  endfunction
  function automatic logic [N-1:0] mact();
    for (int i = 0; i < N; i++) mact[i] = (st[i] >= 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin st[i] = 0; prv[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit waiting, busy, edge_line;
        waiting = (st[i] == 1 || st[i] == 3);
        busy = (st[i] >= 2);
        edge_line = cfg_pulse[i];
        if (exit_stb && exit_idx == i && busy) begin
          busy = 0;
          if (!edge_line) waiting = req[i];
        end
        if (enter_stb && enter_idx == i && (st[i] == 1 || st[i] == 3)) begin
          waiting = 0; busy = 1;
        end
        if (clr_stb && clr_idx == i) begin
          if (edge_line) waiting = 0;
          else if (!req[i]) waiting = 0;
        end
        if (set_stb && set_idx == i) waiting = 1;
        if (edge_line && req[i] && !prv[i]) waiting = 1;
        if (!edge_line && req[i] && !busy) waiting = 1;
        st[i] = (busy ? 2 : 0) + (waiting ? 1 : 0);
        prv[i] = req[i];
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(pending == mpend(), "model pending R2 R3 R4 R6 R7 R8 R9", pending, mpend());
    chk(active == mact(), "model active R5 R8 R9 R10", active, mact());
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    set_stb = 0; clr_stb = 0; enter_stb = 0; exit_stb = 0;
  endtask
  task automatic do_set(input int i);   set_stb = 1;   set_idx = IW'(i);   step(); endtask
  task automatic do_clr(input int i);   clr_stb = 1;   clr_idx = IW'(i);   step(); endtask
  task automatic do_enter(input int i); enter_stb = 1; enter_idx = IW'(i); step(); endtask
  task automatic do_exit(input int i);  exit_stb = 1;  exit_idx = IW'(i);  step(); endtask

  initial begin
    #20000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step();
    chk(pending == 0 && active == 0, "R1 reset idle", pending | active, 0);
    rst_n = 1;

    req[1] = 1; step();
    chk(pending[1], "R2 level pends", pending, 8'h02);
    do_clr(1);
    chk(pending[1], "R6 clear ignored while high", pending, 8'h02);
    req[1] = 0; step(); do_clr(1);
    chk(!pending[1], "R6 clear when low", pending, 0);

    req[5] = 1; step(); req[5] = 0; step();
    chk(pending[5], "R3 one-cycle pulse latched", pending, 8'h20);
    req[6] = 1; step(); step(); do_clr(6); step();
    chk(!pending[6], "R3 held high no retrigger", pending, 8'h20);
    req[6] = 0;

    do_enter(2);
    chk(!active[2], "R5 entry on idle ignored", active, 0);
    do_enter(5);
    chk(active[5] && !pending[5], "R5 entry", {pending[5], active[5]}, 2'b01);

    req[5] = 1; step(); req[5] = 0; step();
    chk(active[5] && pending[5], "R9 edge during service", {pending[5], active[5]}, 2'b11);
    do_exit(5);
    chk(pending[5] && !active[5], "R9 return to waiting", {pending[5], active[5]}, 2'b10);
    do_enter(5); do_exit(5);
    chk(!pending[5] && !active[5], "R9 return idle", {pending[5], active[5]}, 2'b00);

    do_set(4); do_clr(4);
    chk(!pending[4], "R7 edge clear", pending, 0);
    do_set(4); do_enter(4); do_set(4); do_clr(4);
    chk(active[4] && !pending[4], "R7 keeps active", {pending[4], active[4]}, 2'b01);
    do_exit(4);

    req[2] = 1; step(); do_enter(2);
    chk(active[2] && !pending[2], "R8 level in service", {pending[2], active[2]}, 2'b01);
    do_exit(2);
    chk(pending[2] && !active[2], "R8 return high pends", {pending[2], active[2]}, 2'b10);
    do_enter(2); req[2] = 0; step(); do_exit(2);
    chk(!pending[2] && !active[2], "R8 return low idle", {pending[2], active[2]}, 2'b00);

    do_set(3); do_exit(3);
    chk(pending[3] && !active[3], "R10 return ignored", {pending[3], active[3]}, 2'b10);
    do_clr(3);

    set_stb = 1; set_idx = 0; clr_stb = 1; clr_idx = 0; step();
    chk(pending[0], "R4 set beats clear", pending, 8'h01);

    for (int k = 0; k < 600; k++) begin
      req = N'($urandom);
      set_stb = ($urandom % 4) == 0;   set_idx = IW'($urandom);
      clr_stb = ($urandom % 3) == 0;   clr_idx = IW'($urandom);
      enter_stb = ($urandom % 2) == 0; enter_idx = IW'($urandom);
      exit_stb = ($urandom % 2) == 0;  exit_idx = IW'($urandom);
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule